// File: doc/BRIEF.md
# IDCT Output Descale and Pixel Formatter

This block sits at the end of a two-pass inverse DCT for 8x8 blocks. It takes the 16-bit results of the second pass, one column of eight values per beat, and turns each value into an unsigned 8-bit pixel. The conversion first shifts each value right arithmetically by five bits: two fraction bits left over from the first pass, plus three for the divide by eight. It then narrows the result to signed 8 bits with saturation. Finally it adds the centre value 128 with 8-bit wraparound and reads the byte as unsigned. Because of this ordering the 0 to 255 clamp needs no comparator of its own.

Results arrive column by column but must leave as rows of eight bytes, so the block transposes them. It uses a two-half (ping-pong) buffer of 64 bytes per half. While one completed block is read out row by row, the next block can be written into the other half. Both sides use a valid/ready handshake. Output rows carry a 3-bit row index and a last flag on the final row.

Top module: `idct_pixel_fmt`

## Requirements
- R1: Each 16-bit two's-complement input value is shifted right arithmetically by 5 bits, rounding toward negative infinity with no rounding offset (31 gives 0, -1 gives -1, -33 gives -2).
- R2: The shifted value is saturated to the signed 8-bit range -128..127 (inputs of 4064 and above give 127; inputs of -4096 and below give -128).
- R3: The pixel equals the saturated value plus 128 in 8-bit wraparound, read as unsigned, so the pixel is always in 0..255 (127 gives 255, -128 gives 0, 0 gives 128).
- R4: `in_col` bits [16*r+15:16*r] hold row r of the current column. Columns of a block are accepted in order 0 to 7, one per cycle on which `in_valid` and `in_ready` are both high.
- R5: `out_row` bits [8*c+7:8*c] hold the pixel of column c in the row being presented, so column 0 sits in the lowest byte.
- R6: Rows of a block leave in order 0 to 7, with `out_idx` equal to the row number. `out_last` is high exactly while row 7 is presented.
- R7: `out_valid` goes high on the clock edge that accepts the eighth column of a block. Row 0 of that block is then presented in the following cycle, unless an older block is still being read.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_row`, `out_idx` and `out_last` hold their values.
- R9: A new block can be written while the previous one is read out. `in_ready` is low only when both buffer halves hold complete unread blocks. It returns high on the edge that accepts row 7 of the oldest block.
- R10: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input column valid |
| in_ready | output | 1 | Block can accept a column |
| in_col | input | 128 | Eight 16-bit signed values of one column, row 0 lowest |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Consumer accepts the row |
| out_row | output | 64 | Eight pixels of one row, column 0 lowest |
| out_idx | output | 3 | Row number of `out_row` |
| out_last | output | 1 | Row 7 of the block is presented |

## Verification
A column accepted on one edge affects outputs from that edge onward. The edge that accepts the eighth column raises `out_valid` with no further delay. Each accepted row is followed by the next row on the very next cycle. The edge that accepts row 7 of the older block raises `in_ready` again at once. The bench drives inputs and samples outputs on the falling edge. Before each comparison it advances its behavioural model by exactly the handshakes that took place on the rising edge just past. Every output is therefore compared in the cycle it becomes due, including the long stall in which both halves fill up.

// File: rtl/idct_pixel_fmt.sv
module idct_pixel_fmt #(
  parameter int N       = 8,
  parameter int IN_W    = 16,
  parameter int PIX_W   = 8,
  parameter int DESCALE = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N*IN_W-1:0]    in_col,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N*PIX_W-1:0]   out_row,
  output logic [$clog2(N)-1:0] out_idx,
  output logic                 out_last
);
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
  localparam logic signed [IN_W-1:0] SMAX = IN_W'((1 << (PIX_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] SMIN = -SMAX - IN_W'(1);
  localparam logic [PIX_W-1:0] CENTER = PIX_W'(1 << (PIX_W - 1));

  logic [PIX_W-1:0] mem [2][N][N];
  logic [N*PIX_W-1:0] px;
  logic [1:0] full;
  logic wsel, rsel;
  logic [IDX_W-1:0] wcol, rrow;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  genvar r;
  generate
    for (r = 0; r < N; r++) begin : g_cvt
      logic signed [IN_W-1:0] v, sh;
      logic signed [PIX_W-1:0] n8;
      assign v  = in_col[r*IN_W +: IN_W];
      assign sh = v >>> DESCALE;
      assign n8 = (sh > SMAX) ? SMAX[PIX_W-1:0] :
                  (sh < SMIN) ? SMIN[PIX_W-1:0] : sh[PIX_W-1:0];
      assign px[r*PIX_W +: PIX_W] = n8 + CENTER;
    end
  endgenerate

  assign in_ready  = !full[wsel];
  assign out_valid = full[rsel];
  assign out_idx   = rrow;
  assign out_last  = out_valid && (rrow == LAST);

  always_comb begin
    for (int c = 0; c < N; c++) out_row[c*PIX_W +: PIX_W] = mem[rsel][rrow][c];
  end

  always_ff @(posedge clk) begin
    if (in_fire)
      for (int i = 0; i < N; i++) mem[wsel][i][wcol] <= px[i*PIX_W +: PIX_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
      wsel <= 1'b0;
      rsel <= 1'b0;
      wcol <= '0;
      rrow <= '0;
    end else begin
      if (in_fire) begin
        wcol <= wcol + 1'b1;
        if (wcol == LAST) begin
          full[wsel] <= 1'b1;
          wsel <= !wsel;
          wcol <= '0;
        end
      end
      if (out_fire) begin
        rrow <= rrow + 1'b1;
        if (rrow == LAST) begin
          full[rsel] <= 1'b0;
          rsel <= !rsel;
          rrow <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/idct_pixel_fmt_chk.sv
module idct_pixel_fmt_chk #(
  parameter int N     = 8,
  parameter int PIX_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [N*PIX_W-1:0]   out_row,
  input logic [$clog2(N)-1:0] out_idx,
  input logic                 out_last
);
  p_reset_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> in_ready && !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_idx) && $stable(out_last));

  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_idx == $past(out_idx) + 1'b1);

  p_last_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid || out_idx == '0);

  p_blocked_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  p_unblock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && out_ready && out_last |=> in_ready);
endmodule

bind idct_pixel_fmt idct_pixel_fmt_chk #(.N(N), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/tb_idct_pixel_fmt.sv
module tb_idct_pixel_fmt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [127:0] in_col = '0;
  logic in_ready, out_valid, out_last;
  logic [63:0] out_row;
  logic [2:0] out_idx;

  idct_pixel_fmt dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int full_cnt = 0, wcount = 0, ridx = 0, dir_idx = 0;
  logic [7:0] cur [8][8];
  logic [63:0] rows [$];
  bit done = 0;

  function automatic logic [7:0] pix(logic [15:0] raw);
    int v, s;
    v = $signed(raw);
    s = v >>> 5;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return 8'(s + 128);
  endfunction

  function automatic logic [15:0] special(int k);
    case (k % 16)
      0: return 16'd0;       1: return 16'd31;      2: return 16'd32;
      3: return 16'hFFFF;    4: return -16'sd32;    5: return -16'sd33;
      6: return 16'd4064;    7: return 16'd4063;    8: return 16'd4095;
      9: return 16'd4096;    10: return 16'h7FFF;   11: return -16'sd4096;
      12: return -16'sd4097; 13: return 16'h8000;   14: return 16'd100;
      default: return -16'sd100;
    endcase
  endfunction

  function automatic logic [15:0] rnd_val();
    case ($urandom % 4)
      0: return 16'($urandom);
      1: return 16'($signed($urandom % 10000) - 5000);
      2: return 16'($signed($urandom % 400) - 200);
      default: return special($urandom);
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit pv_in = 0, pv_or = 0, in_fire, out_fire, stall;
    logic [127:0] pv_col = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      in_fire  = pv_in && (full_cnt < 2);
      out_fire = pv_or && (full_cnt > 0);
      stall    = !pv_or && (full_cnt > 0);
      if (out_fire) begin
        void'(rows.pop_front());
        ridx++;
        if (ridx == 8) begin ridx = 0; full_cnt--; end
      end
      if (in_fire) begin
        // R4: row r of the column in bits [16r+15:16r]
        for (int r = 0; r < 8; r++) cur[r][wcount] = pix(pv_col[r*16 +: 16]);
        if (dir_idx < 8) dir_idx++;
        wcount++;
        if (wcount == 8) begin
          for (int r = 0; r < 8; r++) begin
            logic [63:0] w;
            for (int c = 0; c < 8; c++) w[c*8 +: 8] = cur[r][c];
            rows.push_back(w);
          end
          wcount = 0;
          full_cnt++;
        end
      end
      chk(in_ready == (full_cnt < 2), "R9 in_ready", 64'(in_ready), 64'(full_cnt < 2));
      chk(out_valid == (full_cnt > 0), stall ? "R8 R7 out_valid" : "R7 out_valid",
          64'(out_valid), 64'(full_cnt > 0));
      if (full_cnt > 0) begin
        chk(out_row == rows[0], stall ? "R8 R5 R1 R2 R3 out_row" : "R5 R1 R2 R3 out_row",
            out_row, rows[0]);
        chk(out_idx == 3'(ridx), "R6 out_idx", 64'(out_idx), 64'(ridx));
        chk(out_last == (ridx == 7), "R6 out_last", 64'(out_last), 64'(ridx == 7));
      end
      if (cyc < 100)       begin pv_in = 1; pv_or = 1; end
      else if (cyc < 400)  begin pv_in = $urandom % 2; pv_or = $urandom % 2; end
      else if (cyc < 500)  begin pv_in = 1; pv_or = 0; end
      else if (cyc < 3800) begin pv_in = ($urandom % 4) != 0; pv_or = ($urandom % 3) != 0; end
      else                 begin pv_in = 0; pv_or = 1; end
      for (int r = 0; r < 8; r++)
        pv_col[r*16 +: 16] = (dir_idx < 8) ? special(r * 8 + dir_idx) : rnd_val();
      in_valid  = pv_in;
      out_ready = pv_or;
      in_col    = pv_col;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule